// File: doc/BRIEF.md
# SYSREF Phase Alignment Controller

This block keeps a low-rate reference clock (sysref) in a fixed phase relation to an external sync pulse, so that every reset or power-up leaves the output at the same phase. A 2-bit mode input selects one of three behaviours. In windowing mode the block measures where the sync rising edge lands against a free-running phase count and reports that position. In sync mode it waits a programmed number of cycles after the edge and then restarts the sysref divider. In request mode it runs the divider and drives the sysref output.

The sync input is captured on falling clock edges, away from the rising edge that the rest of the logic uses. Software runs the block in a fixed order: it measures the edge in windowing mode, writes the delay, performs the sync, and then switches to request mode to get the aligned output. A lockout bit makes the block honour only the first accepted edge of a periodic sync input.

Top module: `sysref_align_ctrl`

## Requirements
- R1: While `rst` is high, `sysref_o`, `win_valid_o` and `win_pos_o` are zero. The mode held internally resets to request (1), and the divider phase resets to 0.
- R2: The output `sysref_o` is 0 two rising edges after `mode_i` takes a value other than 1. The values are 0 for sync, 2 for windowing and 3, which is reserved.
- R3: In request mode the divider period is N = `div_i`, clamped to the range 2..1024. `sysref_o` is high for the first floor(N/2) cycles of each period and low for the rest. After reset is released, the output at rising edge k is high when ((k-1) mod N) < N/2.
- R4: `sync_i` passes through two falling-edge flops. A rise driven just after rising edge n is acted on at rising edge n+2.
- R5: A 6-bit phase count is cleared at the rising edge where windowing mode is first taken. It then advances by one per cycle, modulo 64. An accepted edge copies the count to `win_pos_o` and sets `win_valid_o`. If the mode is applied after edge m and the sync rise is driven after edge m+n, `win_pos_o` reads n mod 64. `win_valid_o` clears when windowing mode is entered.
- R6: In sync mode an accepted edge at rising edge e loads `delay_i` (D) into a counter. The divider restarts at edge f = e+1+D, and from then on the request-mode output at edge k is high when ((k-1-f) mod N) < N/2.
- R7: With `stop_i` low, each new sync rising edge is accepted, so the last edge sets the phase.
- R8: With `stop_i` high, an accepted edge locks the block out, and later edges change neither `win_pos_o` nor the divider phase.
- R9: A change of `mode_i` clears the lockout and cancels a pending delay, so the divider is not restarted.
- R10: In request mode sync edges leave the divider phase and `win_pos_o`/`win_valid_o` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock. Sync capture uses its falling edge; everything else uses its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| mode_i | input | 2 | 0 sync, 1 request, 2 windowing, 3 reserved |
| stop_i | input | 1 | Lock out edges after the first accepted one |
| delay_i | input | 6 | Cycles from the accepted edge to the divider restart |
| div_i | input | 11 | Divider period, clamped to 2..1024 |
| sync_i | input | 1 | External sync pulse, asynchronous |
| sysref_o | output | 1 | Registered sysref output |
| win_pos_o | output | 6 | Phase count captured at the last accepted edge in windowing mode |
| win_valid_o | output | 1 | Set when `win_pos_o` holds a fresh measurement |

## Verification
A sync rise driven just after rising edge n is acted on at edge n+2. The window result is then readable right after that edge. The divider restart lands at n+3+D, and the output in request mode follows that restart one edge later. A mode change reaches the output gating two edges after it is driven. The bench drives inputs and samples outputs 1 ns after each rising edge and keeps its own cycle index. It derives every expected value from these offsets, from the restart cycle it predicted and from the clamped period. It starts comparing sysref only two edges after request mode is applied.

// File: rtl/sysref_align_pkg.sv
package sysref_align_pkg;

  typedef enum logic [1:0] {
    MODE_SYNC = 2'd0,
    MODE_REQ  = 2'd1,
    MODE_WIN  = 2'd2,
    MODE_RSVD = 2'd3
  } align_mode_e;

endpackage

// File: rtl/sync_edge_detect.sv
module sync_edge_detect #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic sync_i,
  output logic rise_o
);
  localparam int LAST = STAGES - 1;

  logic [LAST:0] pipe;
  logic          prev_q;

  // capture chain on the falling edge, clear of the rising-edge window
  generate
    for (genvar g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(negedge clk) begin
          if (rst) pipe[g] <= 1'b0;
          else     pipe[g] <= sync_i;
        end
      end else begin : g_next
        always_ff @(negedge clk) begin
          if (rst) pipe[g] <= 1'b0;
          else     pipe[g] <= pipe[g-1];
        end
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) prev_q <= 1'b1;
    else     prev_q <= pipe[LAST];
  end

  assign rise_o = pipe[LAST] & ~prev_q;

endmodule

// File: rtl/window_meter.sv
module window_meter #(
  parameter int PH_W = 6
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            in_window,
  input  logic            enter,
  input  logic            hit,
  output logic [PH_W-1:0] pos_o,
  output logic            valid_o
);
  logic [PH_W-1:0] phase_q;

  always_ff @(posedge clk) begin
    if (rst || enter)   phase_q <= '0;
    else if (in_window) phase_q <= phase_q + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pos_o   <= '0;
      valid_o <= 1'b0;
    end else if (enter) begin
      valid_o <= 1'b0;
    end else if (hit) begin
      pos_o   <= phase_q;
      valid_o <= 1'b1;
    end
  end

endmodule

// File: rtl/align_delay.sv
module align_delay #(
  parameter int DLY_W = 6
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic             cancel,
  input  logic [DLY_W-1:0] dly_i,
  output logic             busy_o,
  output logic             fire_o
);
  logic [DLY_W-1:0] cnt_q;

  assign fire_o = busy_o && (cnt_q == '0) && !cancel;

  always_ff @(posedge clk) begin
    if (rst || cancel) begin
      busy_o <= 1'b0;
      cnt_q  <= '0;
    end else if (start) begin
      busy_o <= 1'b1;
      cnt_q  <= dly_i;
    end else if (busy_o) begin
      if (cnt_q == '0) busy_o <= 1'b0;
      else             cnt_q  <= cnt_q - 1'b1;
    end
  end

endmodule

// File: rtl/sysref_divider.sv
module sysref_divider #(
  parameter int DIV_W   = 11,
  parameter int DIV_MIN = 2,
  parameter int DIV_MAX = 1024
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr,
  input  logic             en,
  input  logic [DIV_W-1:0] div_i,
  output logic             out_o
);
  localparam logic [DIV_W-1:0] LO = DIV_W'(DIV_MIN);
  localparam logic [DIV_W-1:0] HI = DIV_W'(DIV_MAX);

  logic [DIV_W-1:0] period;
  logic [DIV_W-1:0] half;
  logic [DIV_W-1:0] ph_q;

  always_comb begin
    if (div_i < LO)      period = LO;
    else if (div_i > HI) period = HI;
    else                 period = div_i;
    half = period >> 1;
  end

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      ph_q  <= '0;
      out_o <= 1'b0;
    end else begin
      ph_q  <= (ph_q >= period - 1'b1) ? '0 : ph_q + 1'b1;
      out_o <= en && (ph_q < half);
    end
  end

endmodule

// File: rtl/sysref_align_ctrl.sv
module sysref_align_ctrl
  import sysref_align_pkg::*;
#(
  parameter int DLY_W       = 6,
  parameter int PH_W        = 6,
  parameter int DIV_W       = 11,
  parameter int DIV_MIN     = 2,
  parameter int DIV_MAX     = 1024,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [1:0]       mode_i,
  input  logic             stop_i,
  input  logic [DLY_W-1:0] delay_i,
  input  logic [DIV_W-1:0] div_i,
  input  logic             sync_i,
  output logic             sysref_o,
  output logic [PH_W-1:0]  win_pos_o,
  output logic             win_valid_o
);
  align_mode_e mode_q;
  logic        mode_chg;
  logic        lock_q;
  logic        rise;
  logic        accept;
  logic        dly_busy;
  logic        fire;

  assign mode_chg = (mode_i != mode_q);
  assign accept   = rise && !lock_q && !mode_chg;

  always_ff @(posedge clk) begin
    if (rst) mode_q <= MODE_REQ;
    else     mode_q <= align_mode_e'(mode_i);
  end

  // lockout: taken on an accepted edge when stop is set, released by any mode change
  always_ff @(posedge clk) begin
    if (rst || mode_chg)       lock_q <= 1'b0;
    else if (accept && stop_i) lock_q <= 1'b1;
  end

  sync_edge_detect #(.STAGES(SYNC_STAGES)) u_edge (
    .clk    (clk),
    .rst    (rst),
    .sync_i (sync_i),
    .rise_o (rise)
  );

  window_meter #(.PH_W(PH_W)) u_win (
    .clk       (clk),
    .rst       (rst),
    .in_window (mode_q == MODE_WIN),
    .enter     (mode_chg && (mode_i == MODE_WIN)),
    .hit       (accept && (mode_q == MODE_WIN)),
    .pos_o     (win_pos_o),
    .valid_o   (win_valid_o)
  );

  align_delay #(.DLY_W(DLY_W)) u_dly (
    .clk    (clk),
    .rst    (rst),
    .start  (accept && (mode_q == MODE_SYNC)),
    .cancel (mode_chg),
    .dly_i  (delay_i),
    .busy_o (dly_busy),
    .fire_o (fire)
  );

  sysref_divider #(.DIV_W(DIV_W), .DIV_MIN(DIV_MIN), .DIV_MAX(DIV_MAX)) u_div (
    .clk   (clk),
    .rst   (rst),
    .clr   (fire),
    .en    (mode_q == MODE_REQ),
    .div_i (div_i),
    .out_o (sysref_o)
  );

endmodule

// File: rtl/sysref_align_checker.sv
module sysref_align_checker #(
  parameter int PH_W = 6
) (
  input logic            clk,
  input logic            rst,
  input logic [1:0]      mode_i,
  input logic [1:0]      mode_q,
  input logic            lock_q,
  input logic            dly_busy,
  input logic            sysref_o,
  input logic [PH_W-1:0] win_pos_o,
  input logic            win_valid_o
);

  a_r1_reset_clears: assert property (@(posedge clk)
    rst |=> (!sysref_o && !win_valid_o && win_pos_o == '0));

  a_r2_off_unless_request: assert property (@(posedge clk) disable iff (rst)
    (mode_i != 2'd1) |=> ##1 !sysref_o);

  a_r5_valid_only_in_window: assert property (@(posedge clk) disable iff (rst)
    $rose(win_valid_o) |-> (mode_q == 2'd2));

  a_r8_lock_freezes_result: assert property (@(posedge clk) disable iff (rst)
    (lock_q && (mode_i == mode_q)) |=> $stable(win_pos_o));

  a_r9_change_cancels_delay: assert property (@(posedge clk) disable iff (rst)
    (mode_i != mode_q) |=> !dly_busy);

endmodule

bind sysref_align_ctrl sysref_align_checker #(.PH_W(PH_W)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .mode_i      (mode_i),
  .mode_q      (mode_q),
  .lock_q      (lock_q),
  .dly_busy    (dly_busy),
  .sysref_o    (sysref_o),
  .win_pos_o   (win_pos_o),
  .win_valid_o (win_valid_o)
);

// File: tb/sysref_align_ctrl_bench.sv
`timescale 1ns/1ps
module sysref_align_ctrl_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [1:0]  mode_i = 2'd1;
  logic        stop_i = 1'b0;
  logic [5:0]  delay_i = '0;
  logic [10:0] div_i = 11'd10;
  logic        sync_i = 1'b0;
  logic        sysref_o;
  logic [5:0]  win_pos_o;
  logic        win_valid_o;

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;
  int f_ref  = 0;
  bit done   = 0;

  always #2.5 clk = ~clk;

  sysref_align_ctrl u_sysref_align_ctrl (
    .clk(clk), .rst(rst), .mode_i(mode_i), .stop_i(stop_i), .delay_i(delay_i),
    .div_i(div_i), .sync_i(sync_i), .sysref_o(sysref_o),
    .win_pos_o(win_pos_o), .win_valid_o(win_valid_o)
  );

  function automatic int clamp_n(int raw);
    if (raw < 2) return 2;
    if (raw > 1024) return 1024;
    return raw;
  endfunction

  function automatic int exp_ref(int k, int f, int n);
    return (((k - 1 - f) % n) < (n / 2)) ? 1 : 0;
  endfunction

  task automatic step();
    @(posedge clk); #1;
    cyc++;
  endtask

  task automatic chk(string req, int got, int exp);
    checks++;
    if (got != exp) begin
      fails++;
      $display("FAIL %s at cycle %0d: got %0d expected %0d", req, cyc, got, exp);
    end
  endtask

  // sync rise driven after edge cyc; acted on at cyc+2
  task automatic pulse();
    sync_i = 1'b1; step(); step(); step();
    sync_i = 1'b0; step(); step(); step();
  endtask

  task automatic req_span(string req, int len);
    int n;
    n = clamp_n(int'(div_i));
    for (int i = 0; i < len; i++) begin
      step();
      chk(req, sysref_o, exp_ref(cyc, f_ref, n));
    end
  endtask

  task automatic go_req();
    mode_i = 2'd1; step(); step();
  endtask

  task automatic win_measure(int n, bit expect_new, int old_pos);
    mode_i = 2'd1; step(); step();
    mode_i = 2'd2;
    for (int i = 0; i < n; i++) begin
      step();
      if (i == 0) chk("R5 valid cleared on entry", win_valid_o, 0);
    end
    sync_i = 1'b1; step(); step();
    if (expect_new) chk("R5 window position", win_pos_o, n % 64);
    else            chk("R8 window position locked", win_pos_o, old_pos);
    chk("R5 window valid", win_valid_o, 1);
    chk("R2 sysref off in windowing", sysref_o, 0);
    sync_i = 1'b0; step(); step(); step();
  endtask

  // sync with delay d; optional second edge; returns restart cycle in f_ref
  task automatic do_sync(int d, bit second, bit use_first);
    int fa, fb;
    mode_i = 2'd0; delay_i = 6'(d);
    step(); step();
    fa = cyc + 3 + d;
    pulse();
    fb = fa;
    if (second) begin
      repeat (d + 3) begin
        step(); chk("R2 sysref off in sync", sysref_o, 0);
      end
      fb = cyc + 3 + d;
      pulse();
    end
    repeat (d + 4) begin
      step(); chk("R2 sysref off in sync", sysref_o, 0);
    end
    f_ref = (second && !use_first) ? fb : fa;
  endtask

  initial begin
    #1000000;
    if (!done) begin
      fails++;
      $display("FAIL watchdog (R1..): got no finish, expected finish");
      $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    int seed, p;
    seed = 32'h5a17;
    void'($urandom(seed));
    repeat (4) @(posedge clk);
    #1;
    chk("R1 sysref reset", sysref_o, 0);
    chk("R1 valid reset", win_valid_o, 0);
    chk("R1 pos reset", win_pos_o, 0);
    rst = 1'b0; cyc = 0; f_ref = 0;

    // R3 request mode after reset, then R10 edge in request mode
    req_span("R3 request divider", 40);
    sync_i = 1'b1; step(); chk("R10 ignore in request", sysref_o, exp_ref(cyc, f_ref, 10));
    step(); chk("R10 ignore in request", sysref_o, exp_ref(cyc, f_ref, 10));
    sync_i = 1'b0;
    req_span("R10 phase kept after request edge", 30);
    chk("R10 window untouched", win_valid_o, 0);

    // R2 reserved mode and windowing keep sysref low
    mode_i = 2'd3; step(); step();
    repeat (12) begin step(); chk("R2 sysref off reserved", sysref_o, 0); end
    mode_i = 2'd2; step(); step();
    repeat (12) begin step(); chk("R2 sysref off windowing", sysref_o, 0); end

    // R4/R5 windowing positions, including wrap past 64
    win_measure(1, 1, 0);
    win_measure(63, 1, 0);
    win_measure(64, 1, 0);
    win_measure(130, 1, 0);
    for (int i = 0; i < 4; i++) win_measure(int'($urandom_range(1, 120)), 1, 0);

    // R8 lockout in windowing, R9 mode change re-arms
    stop_i = 1'b1;
    win_measure(17, 1, 0);
    p = int'(win_pos_o);
    repeat (5) step();
    sync_i = 1'b1; step(); step(); step();
    chk("R8 second edge ignored", win_pos_o, p);
    sync_i = 1'b0; step(); step(); step();
    win_measure(29, 1, 0);
    stop_i = 1'b0;

    // R6 sync restart with directed and random delay/period
    div_i = 11'd8;  do_sync(0, 0, 0);  go_req(); req_span("R6 delay 0", 30);
    div_i = 11'd13; do_sync(63, 0, 0); go_req(); req_span("R6 delay 63 odd period", 40);
    for (int i = 0; i < 4; i++) begin
      div_i = 11'($urandom_range(2, 40));
      do_sync(int'($urandom_range(0, 63)), 0, 0);
      repeat (int'($urandom_range(0, 9))) step();
      go_req(); req_span("R6 random sync", 3 * clamp_n(int'(div_i)) + 5);
    end

    // R7 periodic sync: last edge wins
    div_i = 11'd12; do_sync(5, 1, 0); go_req(); req_span("R7 re-sync on later edge", 40);
    // R8 stop: first edge wins
    stop_i = 1'b1;
    div_i = 11'd11; do_sync(4, 1, 1); go_req(); req_span("R8 later sync edge locked out", 40);
    stop_i = 1'b0;

    // R9 mode change cancels a pending restart
    mode_i = 2'd0; delay_i = 6'd50; step(); step();
    pulse(); step(); step();
    go_req(); req_span("R9 pending delay cancelled", 80);

    // R3 clamping of the period
    div_i = 11'd0;    do_sync(2, 0, 0); go_req(); req_span("R3 period clamp low", 20);
    div_i = 11'd2000; do_sync(1, 0, 0); go_req(); req_span("R3 period clamp high", 2100);

    done = 1;
    $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

endmodule